// File: doc/BRIEF.md
# Receive Reference-Voltage Search Sequencer

This block tunes the receiver reference voltage of up to four byte lanes. Each lane has an 8-step voltage index. The register code for an index is not linear. For every index under trial, the block asks an external centralization engine for three eye-width measurements through a request/acknowledge handshake. It then folds the 5-bit results into a running average scaled by 1000, and compares that average with the best window the lane has seen so far. A comparison counts as "no worse" when it falls short of the best by at most 200.

The search has two phases. The coarse phase climbs the index in steps of 3 while the eye does not shrink. The first time the eye shrinks, the fine phase starts: it walks back one index at a time towards a limit placed 3 below the index where the shrink happened. Once a lane has settled, its code freezes. Lanes that are masked off, and lanes whose eye was already wider than 12 before the search, skip tuning entirely. The whole run stops when every lane has settled or when an iteration budget runs out, and a one-cycle done pulse marks the end.

Top module: `vref_search_fsm`

## Requirements
- R1: After reset every lane drives code 1 (index 0), `lane_conv`, `meas_req`, `busy` and `done` are all low.
- R2: The code for index i is (i+1) mod 8, so the code order is 1,2,3,4,5,6,7,0. It appears on bits [4l+3:4l] of `vref_code` for lane l, and bit 4l+3 is always 0.
- R3: A `start` pulse while idle sets every lane to index 0. A lane with `lane_en[l]`=0, or with `pre_win[5l+4:5l]` greater than 12, is marked converged at once and keeps index 0. A value of exactly 12 is tuned.
- R4: Each iteration makes three measurements. `meas_req` stays high until `meas_ack`, and `meas_res[5l+4:5l]` is taken on the acknowledged edge. The average is avg=(avg·(k−1)+1000·res)/k with integer division, for k=1,2,3.
- R5: A trial is no worse when avg+200 ≥ best. When it is no worse, best becomes max(avg,best) and the index under trial is recorded as the best index.
- R6: In the coarse phase, a no-worse trial raises the index by 3, saturating at 7. A no-worse trial at index 7 converges the lane at 7.
- R7: In the coarse phase, a worse trial enters the fine phase. It sets limit = index−3 (floor 0), keeps the best index, and lowers the index by 1.
- R8: In the fine phase, a no-worse trial converges at the current index if index−1 ≤ limit, and otherwise lowers the index by 1. A worse trial restores the best index and converges. A converged lane's code does not change until the next start.
- R9: `done` pulses for one cycle, with no request pending, as soon as all lanes are converged or MAX_ITER iterations have been evaluated. The block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (accepted when idle) |
| lane_en | input | NUM_LANES | Lane active mask |
| pre_win | input | NUM_LANES*5 | Previously measured window per lane |
| meas_req | output | 1 | Measurement request to centralization engine |
| meas_ack | input | 1 | Measurement complete, results valid |
| meas_res | input | NUM_LANES*5 | Per-lane window result |
| vref_code | output | NUM_LANES*4 | Per-lane reference-voltage register code |
| lane_conv | output | NUM_LANES | Per-lane converged flag |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |

## Verification
Two functions can land on the same evaluation: the last lane converging and the iteration budget running out. Both then feed the same termination decision. The bench runs with a budget of five iterations. Its eye profiles peak late, so some lanes settle on exactly the fifth evaluation while others are cut off there. A bench model tracks each lane and judges whether `done` rises at exactly the point the model predicts termination, with every lane's code and flag matching.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int IDX_W  = 3;
  localparam int CODE_W = 4;
  localparam int RES_W  = 5;

  typedef enum logic [1:0] {
    PH_COARSE = 2'd0,
    PH_FINE   = 2'd1,
    PH_DONE   = 2'd2
  } lane_phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CHECK = 2'd1,
    SQ_MEAS  = 2'd2,
    SQ_EVAL  = 2'd3
  } seq_state_e;

  // index -> register code, rotated by one so index 7 wraps to code 0
  function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] idx);
    return CODE_W'(IDX_W'(idx + IDX_W'(1)));
  endfunction
endpackage

// File: rtl/vrs_lane.sv
module vrs_lane
  import vrs_pkg::*;
#(
  parameter int WIN_W   = 16,
  parameter int REP_W   = 2,
  parameter int COARSE  = 3,
  parameter int FINE    = 1,
  parameter int MARGIN  = 200,
  parameter int SCALE   = 1000,
  parameter int SKIP_TH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              en_i,
  input  logic [RES_W-1:0]  pre_win_i,
  input  logic              acc_i,
  input  logic [REP_W-1:0]  rep_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              eval_i,
  output logic [CODE_W-1:0] code_o,
  output logic              conv_o
);
  localparam int IDX_MAX = (1 << IDX_W) - 1;
  localparam int SW      = WIN_W + REP_W + 1;

  lane_phase_e      ph_q, ph_d;
  logic [IDX_W-1:0] cur_q, cur_d, best_q, best_d, lim_q, lim_d;
  logic [WIN_W-1:0] avg_q, avg_d, bw_q, bw_d;
  logic             upd;

  logic [SW-1:0]    sum;
  logic [WIN_W-1:0] avg_new, wmax;
  logic             no_worse, fine_stop;
  logic [IDX_W-1:0] idx_up, idx_dn, idx_lim;

  always_comb begin
    sum       = SW'(avg_q) * (SW'(rep_i) - SW'(1)) + SW'(res_i) * SW'(SCALE);
    avg_new   = (rep_i == '0) ? avg_q : WIN_W'(sum / SW'(rep_i));
    no_worse  = ((WIN_W+1)'(avg_q) + (WIN_W+1)'(MARGIN)) >= (WIN_W+1)'(bw_q);
    wmax      = (avg_q > bw_q) ? avg_q : bw_q;
    idx_up    = (int'(cur_q) + COARSE >= IDX_MAX) ? IDX_W'(IDX_MAX) : IDX_W'(int'(cur_q) + COARSE);
    idx_dn    = (int'(cur_q) >= FINE) ? IDX_W'(int'(cur_q) - FINE) : '0;
    idx_lim   = (int'(cur_q) >= COARSE) ? IDX_W'(int'(cur_q) - COARSE) : '0;
    fine_stop = (int'(cur_q) - FINE) <= int'(lim_q);
  end

  always_comb begin
    ph_d   = ph_q;
    cur_d  = cur_q;
    best_d = best_q;
    lim_d  = lim_q;
    avg_d  = avg_q;
    bw_d   = bw_q;
    if (init_i) begin
      ph_d   = (!en_i || int'(pre_win_i) > SKIP_TH) ? PH_DONE : PH_COARSE;
      cur_d  = '0;
      best_d = '0;
      lim_d  = '0;
      avg_d  = '0;
      bw_d   = '0;
    end else if (acc_i && ph_q != PH_DONE) begin
      avg_d = avg_new;
    end else if (eval_i) begin
      unique case (ph_q)
        PH_COARSE: begin
          if (no_worse) begin
            bw_d   = wmax;
            best_d = cur_q;
            if (int'(cur_q) == IDX_MAX) ph_d = PH_DONE;
            else                        cur_d = idx_up;
          end else begin
            ph_d  = PH_FINE;
            lim_d = idx_lim;
            cur_d = idx_dn;
          end
        end
        PH_FINE: begin
          if (no_worse) begin
            bw_d   = wmax;
            best_d = cur_q;
            if (fine_stop) ph_d = PH_DONE;
            else           cur_d = idx_dn;
          end else begin
            cur_d = best_q;
            ph_d  = PH_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign upd = init_i | acc_i | eval_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_COARSE;
      cur_q  <= '0;
      best_q <= '0;
      lim_q  <= '0;
      avg_q  <= '0;
      bw_q   <= '0;
    end else if (upd) begin
      ph_q   <= ph_d;
      cur_q  <= cur_d;
      best_q <= best_d;
      lim_q  <= lim_d;
      avg_q  <= avg_d;
      bw_q   <= bw_d;
    end
  end

  assign code_o = idx_to_code(cur_q);
  assign conv_o = (ph_q == PH_DONE);
endmodule

// File: rtl/vrs_seq.sv
module vrs_seq
  import vrs_pkg::*;
#(
  parameter int MAX_ITER = 10,
  parameter int REPS     = 3,
  parameter int REP_W    = 2,
  parameter int IT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             all_conv_i,
  input  logic             ack_i,
  output logic             init_o,
  output logic             acc_o,
  output logic             eval_o,
  output logic [REP_W-1:0] rep_o,
  output logic             req_o,
  output logic             done_o,
  output logic             busy_o
);
  seq_state_e       st_q, st_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic [IT_W-1:0]  it_q, it_d;
  logic             finish;

  assign finish = all_conv_i || (it_q == IT_W'(MAX_ITER));

  always_comb begin
    st_d  = st_q;
    rep_d = rep_q;
    it_d  = it_q;
    unique case (st_q)
      SQ_IDLE: if (start_i) begin
        st_d  = SQ_CHECK;
        rep_d = REP_W'(1);
        it_d  = '0;
      end
      SQ_CHECK: st_d = finish ? SQ_IDLE : SQ_MEAS;
      SQ_MEAS: if (ack_i) begin
        if (rep_q == REP_W'(REPS)) begin
          st_d  = SQ_EVAL;
          rep_d = REP_W'(1);
        end else begin
          rep_d = rep_q + REP_W'(1);
        end
      end
      SQ_EVAL: begin
        st_d = SQ_CHECK;
        it_d = it_q + IT_W'(1);
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      rep_q <= REP_W'(1);
      it_q  <= '0;
    end else begin
      st_q  <= st_d;
      rep_q <= rep_d;
      it_q  <= it_d;
    end
  end

  assign init_o = (st_q == SQ_IDLE) && start_i;
  assign req_o  = (st_q == SQ_MEAS);
  assign acc_o  = req_o && ack_i;
  assign eval_o = (st_q == SQ_EVAL);
  assign rep_o  = rep_q;
  assign done_o = (st_q == SQ_CHECK) && finish;
  assign busy_o = (st_q != SQ_IDLE);
endmodule

// File: rtl/vref_search_fsm.sv
module vref_search_fsm
  import vrs_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int MAX_ITER  = 10,
  parameter int REPS      = 3,
  parameter int WIN_W     = 16,
  parameter int SKIP_TH   = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_LANES-1:0]        lane_en,
  input  logic [NUM_LANES*RES_W-1:0]  pre_win,
  output logic                        meas_req,
  input  logic                        meas_ack,
  input  logic [NUM_LANES*RES_W-1:0]  meas_res,
  output logic [NUM_LANES*CODE_W-1:0] vref_code,
  output logic [NUM_LANES-1:0]        lane_conv,
  output logic                        busy,
  output logic                        done
);
  localparam int REP_W = $clog2(REPS + 1);
  localparam int IT_W  = $clog2(MAX_ITER + 1);

  logic             init, acc, eval;
  logic [REP_W-1:0] rep;

  vrs_seq #(
    .MAX_ITER(MAX_ITER), .REPS(REPS), .REP_W(REP_W), .IT_W(IT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .all_conv_i(&lane_conv),
    .ack_i(meas_ack), .init_o(init), .acc_o(acc), .eval_o(eval),
    .rep_o(rep), .req_o(meas_req), .done_o(done), .busy_o(busy)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    vrs_lane #(
      .WIN_W(WIN_W), .REP_W(REP_W), .SKIP_TH(SKIP_TH)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .init_i(init), .en_i(lane_en[l]),
      .pre_win_i(pre_win[l*RES_W +: RES_W]), .acc_i(acc), .rep_i(rep),
      .res_i(meas_res[l*RES_W +: RES_W]), .eval_i(eval),
      .code_o(vref_code[l*CODE_W +: CODE_W]), .conv_o(lane_conv[l])
    );
  end
endmodule

// File: rtl/vrs_chk.sv
module vrs_chk #(
  parameter int NUM_LANES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   meas_req,
  input logic                   meas_ack,
  input logic [NUM_LANES-1:0]   lane_conv,
  input logic [NUM_LANES*4-1:0] vref_code
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && !meas_ack |=> meas_req); // R4
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> busy); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R9
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !meas_req); // R9

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
    AST_START_IDX0: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> vref_code[l*4 +: 4] == 4'd1); // R3
    AST_CONV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lane_conv[l] && !start |=> lane_conv[l] && $stable(vref_code[l*4 +: 4])); // R8
  end
endmodule

bind vref_search_fsm vrs_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .meas_req(meas_req), .meas_ack(meas_ack), .lane_conv(lane_conv),
  .vref_code(vref_code)
);

// File: tb/sim_vref_search_fsm.sv
module sim_vref_search_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int L          = 4;
  localparam int MAXIT      = 5;
  localparam int WD_CYCLES  = 150000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [L-1:0] lane_en;
  logic [L*5-1:0] pre_win;
  logic         meas_req;
  logic         meas_ack;
  logic [L*5-1:0] meas_res;
  logic [L*4-1:0] vref_code;
  logic [L-1:0] lane_conv;
  logic         busy;
  logic         done;

  vref_search_fsm #(.NUM_LANES(L), .MAX_ITER(MAXIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_en(lane_en), .pre_win(pre_win),
    .meas_req(meas_req), .meas_ack(meas_ack), .meas_res(meas_res),
    .vref_code(vref_code), .lane_conv(lane_conv), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit wd    = 1'b0;

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    wd = 1'b1;
  end

  // bench reference model, one entry per lane
  int prof [L][8];
  int m_ph [L];   // 0 coarse, 1 fine, 2 converged
  int m_cur[L];
  int m_best[L];
  int m_lim[L];
  int m_avg[L];
  int m_bw [L];
  int m_iter;
  bit noisy;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int code_of(input int idx);
    return (idx + 1) % 8;
  endfunction

  function automatic bit model_term();
    bit all = 1'b1;
    for (int l = 0; l < L; l++) if (m_ph[l] != 2) all = 1'b0;
    return all || (m_iter == MAXIT);
  endfunction

  task automatic model_eval();
    for (int l = 0; l < L; l++) begin
      bit nw;
      if (m_ph[l] == 2) continue;
      nw = (m_avg[l] + 200 >= m_bw[l]);
      if (m_ph[l] == 0) begin
        if (nw) begin
          m_bw[l] = (m_avg[l] > m_bw[l]) ? m_avg[l] : m_bw[l];
          m_best[l] = m_cur[l];
          if (m_cur[l] == 7) m_ph[l] = 2;
          else m_cur[l] = (m_cur[l] + 3 > 7) ? 7 : m_cur[l] + 3;
        end else begin
          m_ph[l] = 1;
          m_lim[l] = (m_cur[l] >= 3) ? m_cur[l] - 3 : 0;
          m_cur[l] = (m_cur[l] > 0) ? m_cur[l] - 1 : 0;
        end
      end else begin
        if (nw) begin
          m_bw[l] = (m_avg[l] > m_bw[l]) ? m_avg[l] : m_bw[l];
          m_best[l] = m_cur[l];
          if (m_cur[l] - 1 <= m_lim[l]) m_ph[l] = 2;
          else m_cur[l] = m_cur[l] - 1;
        end else begin
          m_cur[l] = m_best[l];
          m_ph[l] = 2;
        end
      end
    end
    m_iter++;
  endtask

  task automatic run_search(input logic [L-1:0] en, input logic [L*5-1:0] pw);
    bit fin = 1'b0;
    int rep = 1;
    lane_en = en;
    pre_win = pw;
    m_iter  = 0;
    for (int l = 0; l < L; l++) begin
      m_ph[l]  = (!en[l] || int'(pw[l*5 +: 5]) > 12) ? 2 : 0;
      m_cur[l] = 0; m_best[l] = 0; m_lim[l] = 0; m_avg[l] = 0; m_bw[l] = 0;
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int l = 0; l < L; l++) begin
      check(lane_conv[l] == (m_ph[l] == 2), "R3 skip flag", int'(lane_conv[l]), int'(m_ph[l] == 2));
      check(vref_code[l*4 +: 4] == 4'd1, "R3 start index", int'(vref_code[l*4 +: 4]), 1);
    end
    while (!fin && !wd) begin
      if (done) begin
        check(model_term(), "R9 done timing", 1, int'(model_term()));
        fin = 1'b1;
      end else if (meas_req) begin
        check(!model_term(), "R9 request after end", 1, int'(!model_term()));
        if (rep == 1)
          for (int l = 0; l < L; l++)
            check(vref_code[l*4 +: 4] == 4'(code_of(m_cur[l])), "R2/R6/R7 code under trial",
                  int'(vref_code[l*4 +: 4]), code_of(m_cur[l]));
        for (int l = 0; l < L; l++) begin
          int r = prof[l][m_cur[l]];
          if (noisy) r = r + int'($urandom_range(2)) - 1;
          if (r < 0) r = 0;
          if (r > 31) r = 31;
          meas_res[l*5 +: 5] = 5'(r);
          if (m_ph[l] != 2) m_avg[l] = (m_avg[l] * (rep - 1) + 1000 * r) / rep;
        end
        meas_ack = 1'b1;
        @(negedge clk);
        meas_ack = 1'b0;
        rep++;
        if (rep > 3) begin
          rep = 1;
          model_eval();
        end
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    check(!busy && !done, "R9 back to idle", int'(busy), 0);
    for (int l = 0; l < L; l++) begin
      check(lane_conv[l] == (m_ph[l] == 2), "R8 final flag", int'(lane_conv[l]), int'(m_ph[l] == 2));
      check(vref_code[l*4 +: 4] == 4'(code_of(m_cur[l])), "R8 final code",
            int'(vref_code[l*4 +: 4]), code_of(m_cur[l]));
    end
  endtask

  initial begin
    void'($urandom(32'd7331));
    rst_n = 1'b0; start = 1'b0; meas_ack = 1'b0; meas_res = '0;
    lane_en = '0; pre_win = '0; noisy = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int l = 0; l < L; l++)
      check(vref_code[l*4 +: 4] == 4'd1 && !lane_conv[l], "R1 reset lane",
            int'(vref_code[l*4 +: 4]), 1);
    check(!meas_req && !busy && !done, "R1 reset control", int'({meas_req, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // rising eye: coarse climb 0,3,6,7 converges at code 0 (R6)
    for (int l = 0; l < L; l++) for (int i = 0; i < 8; i++) prof[l][i] = 2 * i + l;
    run_search(4'hF, '0);
    for (int l = 0; l < L; l++)
      check(vref_code[l*4 +: 4] == 4'd0, "R6 top index code", int'(vref_code[l*4 +: 4]), 0);

    // skip threshold and masking (R3), peak at 3
    for (int l = 0; l < L; l++) for (int i = 0; i < 8; i++) prof[l][i] = 20 - 3 * ((i > 3) ? i - 3 : 3 - i);
    run_search(4'b1011, {5'd31, 5'd0, 5'd12, 5'd13});

    // peak at 6, drop at 7: fine phase walks back (R7 R8)
    for (int l = 0; l < L; l++) for (int i = 0; i < 8; i++) prof[l][i] = (i == 7) ? 2 : 10 + i;
    run_search(4'hF, '0);

    // every lane already wide: zero iterations (R9)
    run_search(4'hF, {5'd20, 5'd13, 5'd31, 5'd25});

    // random profiles, masks, pre-windows with noise (R4 R5)
    noisy = 1'b1;
    for (int t = 0; t < 40 && !wd; t++) begin
      logic [L*5-1:0] pw;
      for (int l = 0; l < L; l++) begin
        for (int i = 0; i < 8; i++) prof[l][i] = int'($urandom_range(31));
        pw[l*5 +: 5] = ($urandom_range(3) == 0) ? 5'($urandom_range(31)) : 5'($urandom_range(12));
      end
      run_search(4'($urandom_range(15)) | 4'b0001, pw);
    end

    if (wd) check(1'b0, "watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule